// File: doc/BRIEF.md
# PLL Start-up Reset and Calibration Sequencer

This block orders the start-up of a digitally controlled PLL. After the power-on reset it pulses a logic reset for a fixed number of clocks. It then starts the loop-gain calibration engine with a one-cycle strobe. Once that engine reports done, the block enables lock acquisition. When the reference-mode flag is set, the sequencer also holds off calibration until the reference clock is reported valid.

A board-level reset/calibrate pin can request the same sequence again. The pin is resynchronised, and the time it stays high is measured in system clocks. A request takes effect only at the falling edge, and only if the high time reached a parameterised minimum. Shorter pulses leave the running state untouched. If the pin rises while calibration is in progress, the calibration is abandoned. The sequencer then waits for the pin to drop and restarts from the logic reset.

Top module: `calseq_top`

## Requirements
- R1: While `rst` is high, `logic_rst`, `cal_start` and `acq_en` are all 0.
- R2: After `rst` is released, `logic_rst` is high for exactly `RST_CYC` consecutive cycles. No calibration pulse occurs before that run ends.
- R3: With `ref_mode` = 0, `cal_start` is high for exactly one cycle. That cycle immediately follows the last cycle of `logic_rst`.
- R4: With `ref_mode` = 1, `cal_start` stays 0 after the logic reset while `ref_ok` is 0. It pulses in the cycle after `ref_ok` is first sampled high.
- R5: `acq_en` goes high in the cycle after `cal_done` is sampled high during calibration. It stays high until a new sequence starts.
- R6: A high level on `cal_pin` lasting at least `MIN_HIGH_CYC` clock cycles starts a new sequence once the pin falls. `logic_rst` rises on the third clock edge after the pin is sampled low, because of the two-stage synchroniser.
- R7: A high pulse on `cal_pin` shorter than `MIN_HIGH_CYC` cycles during acquisition is ignored: `acq_en` stays 1 and `logic_rst` stays 0.
- R8: If the synchronised pin is high while calibration is pending, the calibration is aborted. This takes priority over a `cal_done` in the same cycle, so `acq_en` stays 0. The next fall of the pin, of any length, restarts the sequence with a logic reset.
- R9: While a qualifying pin pulse is still high during acquisition, `acq_en` stays 1. The restart happens only at release.
- R10: `logic_rst` and `acq_en` are never high together, and `cal_start` is never high with either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| cal_pin | input | 1 | Asynchronous reset/calibrate request pin |
| ref_mode | input | 1 | 1 = an external reference clock is used |
| ref_ok | input | 1 | External reference reported valid |
| cal_done | input | 1 | Calibration engine finished |
| logic_rst | output | 1 | Reset to the PLL digital logic |
| cal_start | output | 1 | One-cycle calibration start strobe |
| acq_en | output | 1 | Enable for lock acquisition |

## Verification
Two events can reach the state machine in the same clock: the calibration engine's done report and the synchronised pin rising. The bench raises the pin while calibration is pending. It times `cal_done` to land exactly in the cycle when the synchronised level first becomes visible. The abort must win. The check is that `acq_en` stays low for the whole time the pin is held. A second `cal_start` must also follow only after the pin is released and a fresh logic reset has been given.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PIN_HIGH  = 3'd1,
        ST_RESET     = 3'd2,
        ST_WAIT_REF  = 3'd3,
        ST_CALIBRATE = 3'd4,
        ST_ACQUIRE   = 3'd5
    } seq_state_e;

    // Events produced by the pin qualifier for the state machine
    typedef struct packed {
        logic level;    // synchronised pin level
        logic fall;     // pin dropped this cycle (any width)
        logic fall_ok;  // pin dropped after a qualified high time
    } pin_evt_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/calseq_pin_qual.sv
module calseq_pin_qual
    import calseq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned MIN_HIGH_CYC = 100
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_raw,
    output pin_evt_t evt
);
    localparam int unsigned CW = cnt_width(MIN_HIGH_CYC);
    localparam logic [CW-1:0] CNT_MAX = CW'(MIN_HIGH_CYC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic [CW-1:0]          hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    // Number of cycles the synchronised pin has been high, saturating
    always_ff @(posedge clk) begin
        if (rst || !pin_s)          hi_cnt <= '0;
        else if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
    end

    always_comb begin
        evt.level   = pin_s;
        evt.fall    = !pin_s && (hi_cnt != '0);
        evt.fall_ok = !pin_s && (hi_cnt >= CNT_MAX);
    end

endmodule

// File: rtl/calseq_hold_timer.sv
module calseq_hold_timer #(
    parameter int unsigned RST_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = calseq_pkg::cnt_width(RST_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == CW'(RST_CYC - 1));

endmodule

// File: rtl/calseq_fsm.sv
module calseq_fsm
    import calseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pin_evt_t   evt,
    input  logic       ref_mode,
    input  logic       ref_ok,
    input  logic       cal_done,
    input  logic       hold_done,
    output seq_state_e state,
    output logic       cal_start
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      nxt = evt.level ? ST_PIN_HIGH : ST_RESET;
            ST_PIN_HIGH:  if (evt.fall) nxt = ST_RESET;
            ST_RESET:     if (hold_done) nxt = ref_mode ? ST_WAIT_REF : ST_CALIBRATE;
            ST_WAIT_REF: begin
                if (evt.fall_ok)            nxt = ST_RESET;
                else if (ref_ok || !ref_mode) nxt = ST_CALIBRATE;
            end
            ST_CALIBRATE: begin
                if (evt.level)     nxt = ST_PIN_HIGH;  // abort beats done
                else if (cal_done) nxt = ST_ACQUIRE;
            end
            ST_ACQUIRE:   if (evt.fall_ok) nxt = ST_RESET;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cal_start <= 1'b0;
        end else begin
            state     <= nxt;
            cal_start <= (nxt == ST_CALIBRATE) && (state != ST_CALIBRATE);
        end
    end

endmodule

// File: rtl/calseq_top.sv
module calseq_top
    import calseq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned MIN_HIGH_CYC = 100,
    parameter int unsigned RST_CYC      = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cal_pin,
    input  logic ref_mode,
    input  logic ref_ok,
    input  logic cal_done,
    output logic logic_rst,
    output logic cal_start,
    output logic acq_en
);
    pin_evt_t   evt;
    seq_state_e state;
    logic       hold_done;
    logic       in_reset;

    assign in_reset = (state == ST_RESET);

    calseq_pin_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_HIGH_CYC(MIN_HIGH_CYC)
    ) u_pin (
        .clk    (clk),
        .rst    (rst),
        .pin_raw(cal_pin),
        .evt    (evt)
    );

    calseq_hold_timer #(
        .RST_CYC(RST_CYC)
    ) u_hold (
        .clk (clk),
        .rst (rst),
        .run (in_reset),
        .done(hold_done)
    );

    calseq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .ref_mode (ref_mode),
        .ref_ok   (ref_ok),
        .cal_done (cal_done),
        .hold_done(hold_done),
        .state    (state),
        .cal_start(cal_start)
    );

    assign logic_rst = in_reset;
    assign acq_en    = (state == ST_ACQUIRE);

endmodule

// File: rtl/calseq_chk.sv
module calseq_chk #(
    parameter int unsigned RST_CYC = 8
) (
    input logic clk,
    input logic rst,
    input logic ref_mode,
    input logic ref_ok,
    input logic cal_done,
    input logic logic_rst,
    input logic cal_start,
    input logic acq_en
);
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)            run_len <= '0;
        else if (logic_rst) run_len <= run_len + 1;
        else                run_len <= '0;
    end

    // R2: every logic reset run lasts RST_CYC cycles
    p_rst_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(logic_rst) |-> (run_len == RST_CYC));

    // R3: start strobe is a single cycle
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        cal_start |=> !cal_start);

    // R4: in reference mode calibration only starts with a valid reference
    p_ref_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (cal_start && $past(ref_mode)) |-> $past(ref_ok));

    // R5: acquisition only follows a completed calibration
    p_acq_after_done_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(acq_en) |-> $past(cal_done));

    // R10: outputs mutually exclusive
    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({logic_rst, cal_start, acq_en}) <= 1);

    // R1: nothing driven during power-on reset
    always @(negedge clk) begin
        if (rst) begin
            a_idle_r1: assert (!logic_rst && !cal_start && !acq_en);
        end
    end

endmodule

bind calseq_top calseq_chk #(.RST_CYC(RST_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_mode (ref_mode),
    .ref_ok   (ref_ok),
    .cal_done (cal_done),
    .logic_rst(logic_rst),
    .cal_start(cal_start),
    .acq_en   (acq_en)
);

// File: tb/calseq_top_tb.sv
module calseq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_HI     = 16;
    localparam int RST_N      = 8;

    // pulse width, expected restart (1) or ignored (0)
    localparam int NVEC = 6;
    localparam int VEC [NVEC][2] = '{
        '{3, 0}, '{10, 0}, '{MIN_HI-1, 0}, '{MIN_HI, 1}, '{MIN_HI+5, 1}, '{40, 1}
    };

    logic clk = 0;
    logic rst = 1;
    logic cal_pin = 0, ref_mode = 0, ref_ok = 0, cal_done = 0;
    logic logic_rst, cal_start, acq_en;
    int   errors = 0;
    int   checks = 0;
    int   excl_bad = 0;
    bit   done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    calseq_top #(.SYNC_STAGES(2), .MIN_HIGH_CYC(MIN_HI), .RST_CYC(RST_N)) u_dut (
        .clk(clk), .rst(rst), .cal_pin(cal_pin), .ref_mode(ref_mode),
        .ref_ok(ref_ok), .cal_done(cal_done),
        .logic_rst(logic_rst), .cal_start(cal_start), .acq_en(acq_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // R10 monitor
    always @(negedge clk) begin
        if (!rst && ((logic_rst + cal_start + acq_en) > 1)) excl_bad++;
    end

    task automatic wait_start(output bit got);
        got = 0;
        for (int i = 0; i < 200 && !got; i++) begin
            tick();
            if (cal_start) got = 1;
        end
    endtask

    task automatic complete_cal(input string req);
        cal_done = 1;
        tick();
        cal_done = 0;
        chk(acq_en == 1, req, "acq_en after cal_done", acq_en, 1);
    endtask

    task automatic watch_reset(input int n, output bit saw);
        saw = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (logic_rst) saw = 1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit got;
        bit saw;
        int run;
        bit held_ok;

        // R1: reset state
        repeat (4) tick();
        chk(!logic_rst && !cal_start && !acq_en, "R1", "outputs in reset",
            {logic_rst, cal_start, acq_en}, 0);
        rst = 0;

        // R2 / R3: power-up sequence
        run = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (logic_rst) run++;
            else if (run != 0) break;
        end
        chk(run == RST_N, "R2", "logic_rst length", run, RST_N);
        chk(cal_start == 1, "R3", "cal_start after reset", cal_start, 1);
        tick();
        chk(cal_start == 0, "R3", "cal_start one cycle", cal_start, 0);
        chk(acq_en == 0, "R5", "no acq before done", acq_en, 0);
        complete_cal("R5");
        repeat (5) tick();
        chk(acq_en == 1, "R5", "acq_en held", acq_en, 1);

        // R6 / R7 / R9: pulse-width table
        for (int v = 0; v < NVEC; v++) begin
            held_ok = 1;
            cal_pin = 1;
            for (int i = 0; i < VEC[v][0]; i++) begin
                tick();
                if (!acq_en) held_ok = 0;
            end
            cal_pin = 0;
            chk(held_ok, "R9", "acq_en while pin high", held_ok, 1);
            watch_reset(6, saw);
            chk(saw == VEC[v][1], VEC[v][1] ? "R6" : "R7",
                $sformatf("restart for width %0d", VEC[v][0]), saw, VEC[v][1]);
            if (saw) begin
                wait_start(got);
                chk(got, "R6", "cal_start after restart", got, 1);
                complete_cal("R6");
            end else begin
                chk(acq_en == 1, "R7", "acq_en after short pulse", acq_en, 1);
            end
        end

        // R4: reference mode gating
        ref_mode = 1;
        ref_ok   = 0;
        cal_pin  = 1;
        repeat (MIN_HI + 2) tick();
        cal_pin = 0;
        watch_reset(6, saw);
        chk(saw, "R4", "restart in ref mode", saw, 1);
        for (int i = 0; i < 30 && logic_rst; i++) tick();
        got = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (cal_start) got = 1;
        end
        chk(!got, "R4", "no cal_start without ref_ok", got, 0);
        ref_ok = 1;
        tick();
        chk(cal_start == 1, "R4", "cal_start after ref_ok", cal_start, 1);
        ref_mode = 0;
        ref_ok   = 0;

        // R8: pin rises during calibration, cal_done collides with abort
        tick();
        cal_pin = 1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        cal_done = 1;
        tick();
        cal_done = 0;
        got = 0;
        held_ok = 1;
        for (int i = 0; i < 8; i++) begin
            tick();
            if (acq_en) held_ok = 0;
            if (cal_start) got = 1;
        end
        chk(held_ok, "R8", "abort wins over cal_done", !held_ok, 0);
        chk(!got, "R8", "no cal_start while pin high", got, 0);
        cal_pin = 0;  // total width under MIN_HI still restarts
        watch_reset(6, saw);
        chk(saw, "R8", "restart after aborted cal", saw, 1);
        wait_start(got);
        chk(got, "R8", "cal_start after abort", got, 1);
        complete_cal("R8");

        chk(excl_bad == 0, "R10", "output exclusivity violations", excl_bad, 0);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule